// File: doc/BRIEF.md
# Dual-Line Serial Flash Boot Copier

This block fills an on-chip word-wide RAM with a program image held in an external serial flash, with no processor involvement. After a start pulse it selects the flash, sends a dual-output read command and a 24-bit start address on one data line, and waits out eight dummy clocks. It then turns both data lines into inputs and collects two bits per serial clock.

Every sixteen serial clocks make one 32-bit word, which is written to RAM in a single write cycle. A hardware word counter ends the burst once the whole image has been copied. The default image is 8192 words (32 kB) starting at flash address 0x0F8000, which is the top 32 kB of a 1 MB device.

The serial clock runs in SPI mode 0 at the system clock divided by twice a parameter. That parameter is chosen so the serial clock stays inside the flash's read limit. A done flag reports completion, and a new start pulse after done repeats the copy.

Top module: `dspi_boot_loader`

## Requirements
- R1: While reset is held and after its release, chip select is high, the serial clock is low, busy, done, ram_we and io0_oe are low.
- R2: The serial clock idles low and toggles only while chip select is low; io0_o changes only while the serial clock is low.
- R3: The first 32 rising serial edges carry the command byte 0x3B and then the 24-bit parameter START_ADDR on io0_o, most significant bit first.
- R4: io0_oe is high through the 32 header bits and goes low at the falling edge that follows the last address bit. It stays low for the 8 dummy clocks and the data phase.
- R5: In the data phase both lines are sampled on the rising serial edge. Within each byte, io1 supplies bits 7, 5, 3, 1 and io0 supplies bits 6, 4, 2, 0, in that time order.
- R6: Every 16 data clocks produce one ram_we pulse. The word is packed little-endian, so the lowest flash address lands in bits 7:0. ram_addr is 0 for the first word and goes up by one per word.
- R7: After exactly WORDS words (40 + 16·WORDS serial clocks in all), chip select goes high at the falling edge and no further clock or write occurs.
- R8: Chip select stays high for at least one serial clock period (2·HALF system clocks) before done rises. Done then stays high until the next start.
- R9: Busy is high from the cycle after an accepted start until done. A start pulse while busy has no effect on the burst.
- R10: A start pulse while done is high clears done and performs a complete new copy from word 0.
- R11: Each serial clock half period lasts exactly HALF system clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle request to begin a copy |
| busy | output | 1 | Copy in progress |
| done | output | 1 | Image fully copied |
| flash_cs_n | output | 1 | Flash chip select, active low |
| flash_sck | output | 1 | Flash serial clock, mode 0 |
| io0_o | output | 1 | Data line 0 output value |
| io0_oe | output | 1 | Data line 0 output enable |
| io0_i | input | 1 | Data line 0 input value |
| io1_i | input | 1 | Data line 1 input value |
| ram_we | output | 1 | RAM write strobe |
| ram_addr | output | RAM_AW | RAM word address |
| ram_wdata | output | 32 | RAM write word |

## Verification
The hardest moments to reach from the ports are the phase boundaries. The first is the hand-over of line 0 from driver to receiver after the last address bit. The second is the single falling edge at which the final word completes and chip select must rise. The bench reaches them with a behavioural flash that counts rising clock edges, decodes the header it receives and answers with an address-dependent byte pattern. Every clock, it checks the enable, edge spacing and write contents against its own counts.

Start pulses are also injected in the header, data and closing gap phases to show they are ignored. A restart from done uses a different flash pattern, so the second copy cannot reuse data left over from the first.

// File: rtl/dspi_boot_pkg.sv
package dspi_boot_pkg;
  typedef enum logic [2:0] {ST_IDLE, ST_HDR, ST_DATA, ST_GAP, ST_DONE} boot_state_t;

  localparam logic [7:0] DUAL_READ_CMD = 8'h3B;
  localparam int         HDR_OUT_BITS  = 32;   // command + address
  localparam int         HDR_RISES     = 40;   // plus 8 dummy clocks

  // Bit position of the lower bit of a data pair within the 32-bit word.
  // pair[3:2] selects the byte, pair[1:0] the pair within it (MSB pair first).
  function automatic logic [4:0] pair_lsb(input logic [3:0] pair);
    return {pair[3:2], 3'b110} - {2'b00, pair[1:0], 1'b0};
  endfunction
endpackage

// File: rtl/dspi_sck_gen.sv
module dspi_sck_gen #(
  parameter int HALF = 1,
  localparam int CW = (HALF > 1) ? $clog2(HALF) : 1
)(
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic sck,
  output logic rise,
  output logic fall
);
  logic [CW-1:0] cnt;
  logic          tick;

  assign tick = run && (cnt == CW'(HALF - 1));
  assign rise = tick && !sck;
  assign fall = tick && sck;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      sck <= 1'b0;
    end else if (!run) begin
      cnt <= '0;
      sck <= 1'b0;
    end else if (tick) begin
      cnt <= '0;
      sck <= !sck;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  assert_edge_alternates_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);
endmodule

// File: rtl/dspi_word_packer.sv
module dspi_word_packer import dspi_boot_pkg::*; (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clr,
  input  logic        cap,
  input  logic        d_hi,
  input  logic        d_lo,
  output logic        word_end,
  output logic        wr_valid,
  output logic [31:0] wr_word
);
  logic [3:0]  pair;
  logic [31:0] acc, acc_next;
  logic [4:0]  lo;

  assign lo       = pair_lsb(pair);
  assign word_end = cap && (pair == 4'hF);

  always_comb begin
    acc_next              = acc;
    acc_next[lo + 5'd1]   = d_hi;
    acc_next[lo]          = d_lo;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pair     <= '0;
      acc      <= '0;
      wr_valid <= 1'b0;
      wr_word  <= '0;
    end else if (clr) begin
      pair     <= '0;
      acc      <= '0;
      wr_valid <= 1'b0;
    end else begin
      wr_valid <= word_end;
      if (cap) begin
        acc  <= acc_next;
        pair <= pair + 1'b1;
        if (pair == 4'hF) wr_word <= acc_next;
      end
    end
  end

  assert_single_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |=> !wr_valid);
endmodule

// File: rtl/dspi_boot_loader.sv
module dspi_boot_loader import dspi_boot_pkg::*; #(
  parameter logic [23:0] START_ADDR = 24'h0F8000,
  parameter int          WORDS      = 8192,
  parameter int          HALF       = 1,
  localparam int         RAM_AW     = $clog2(WORDS)
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              busy,
  output logic              done,
  output logic              flash_cs_n,
  output logic              flash_sck,
  output logic              io0_o,
  output logic              io0_oe,
  input  logic              io0_i,
  input  logic              io1_i,
  output logic              ram_we,
  output logic [RAM_AW-1:0] ram_addr,
  output logic [31:0]       ram_wdata
);
  localparam int GAP_CYC = 2 * HALF;
  localparam int GW      = $clog2(GAP_CYC) + 1;

  boot_state_t       st;
  logic [5:0]        pos;
  logic [31:0]       shreg;
  logic [RAM_AW-1:0] wcnt;
  logic              last_word;
  logic [GW-1:0]     gcnt;
  logic              oe_q, cs_q;

  // named internal events
  logic sck_rise, sck_fall, run, accept, word_end, hdr_done, copy_end;

  assign run      = (st == ST_HDR) || (st == ST_DATA);
  assign accept   = start && ((st == ST_IDLE) || (st == ST_DONE));
  assign hdr_done = (st == ST_HDR) && sck_rise && (pos == 6'(HDR_RISES - 1));
  assign copy_end = (st == ST_DATA) && sck_fall && last_word;

  dspi_sck_gen #(.HALF(HALF)) u_sck (
    .clk(clk), .rst_n(rst_n), .run(run),
    .sck(flash_sck), .rise(sck_rise), .fall(sck_fall)
  );

  dspi_word_packer u_pack (
    .clk(clk), .rst_n(rst_n), .clr(accept),
    .cap((st == ST_DATA) && sck_rise),
    .d_hi(io1_i), .d_lo(io0_i),
    .word_end(word_end), .wr_valid(ram_we), .wr_word(ram_wdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      pos       <= '0;
      shreg     <= '0;
      wcnt      <= '0;
      last_word <= 1'b0;
      gcnt      <= '0;
      oe_q      <= 1'b0;
      cs_q      <= 1'b1;
      ram_addr  <= '0;
    end else begin
      unique case (st)
        ST_IDLE, ST_DONE: if (accept) begin
          st        <= ST_HDR;
          cs_q      <= 1'b0;
          oe_q      <= 1'b1;
          shreg     <= {DUAL_READ_CMD, START_ADDR};
          pos       <= '0;
          wcnt      <= '0;
          last_word <= 1'b0;
        end
        ST_HDR: begin
          if (sck_rise) begin
            pos <= pos + 1'b1;
            if (hdr_done) st <= ST_DATA;
          end
          if (sck_fall) begin
            shreg <= {shreg[30:0], 1'b0};
            if (pos == 6'(HDR_OUT_BITS)) oe_q <= 1'b0;
          end
        end
        ST_DATA: begin
          if (word_end) begin
            ram_addr <= wcnt;
            wcnt     <= wcnt + 1'b1;
            if (wcnt == RAM_AW'(WORDS - 1)) last_word <= 1'b1;
          end
          if (copy_end) begin
            st   <= ST_GAP;
            cs_q <= 1'b1;
            gcnt <= '0;
          end
        end
        ST_GAP: begin
          if (gcnt == GW'(GAP_CYC - 1)) st <= ST_DONE;
          else gcnt <= gcnt + 1'b1;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign flash_cs_n = cs_q;
  assign io0_o      = shreg[31];
  assign io0_oe     = oe_q;
  assign busy       = (st == ST_HDR) || (st == ST_DATA) || (st == ST_GAP);
  assign done       = (st == ST_DONE);

  assert_sck_needs_select_R2: assert property (@(posedge clk) disable iff (!rst_n)
    flash_sck |-> !flash_cs_n);
  assert_mosi_stable_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (flash_sck && io0_oe) |-> $stable(io0_o));
  assert_line_released_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_DATA) |-> !io0_oe);
  assert_no_extra_word_R7: assert property (@(posedge clk) disable iff (!rst_n)
    word_end |-> !last_word);
  assert_write_while_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> busy);
  assert_gap_before_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> (flash_cs_n && $past(flash_cs_n)));
  assert_busy_done_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));
  assert_start_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (start && (st == ST_DATA)) |=> (st != ST_HDR));
endmodule

// File: tb/test_dspi_boot_loader.sv
module test_dspi_boot_loader;
  localparam int          W  = 6;
  localparam int          H  = 2;
  localparam logic [23:0] SA = 24'h0F8000;
  localparam int          AW = $clog2(W);

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic busy, done, flash_cs_n, flash_sck, io0_o, io0_oe, ram_we;
  logic [AW-1:0] ram_addr;
  logic [31:0]   ram_wdata;
  logic fl_io0 = 1'b0, fl_io1 = 1'b0;
  wire  io0_bus = io0_oe ? io0_o : fl_io0;

  int checks = 0, errors = 0, seed = 1;

  always #10 clk = !clk;

  dspi_boot_loader #(.START_ADDR(SA), .WORDS(W), .HALF(H)) i_dspi_boot_loader (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .flash_cs_n(flash_cs_n), .flash_sck(flash_sck), .io0_o(io0_o), .io0_oe(io0_oe),
    .io0_i(io0_bus), .io1_i(fl_io1),
    .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] fbyte(input int a, input int s);
    return 8'((a * 37 + s * 11) ^ (a >> 3) ^ (s << 4));
  endfunction

  function automatic logic [31:0] exp_word(input int w);
    logic [31:0] r;
    for (int b = 0; b < 4; b++) r[8*b +: 8] = fbyte(int'(SA) + 4*w + b, seed);
    return r;
  endfunction

  // behavioural flash
  int rcnt = 0, cs_falls = 0, p_idx = 0, b_idx = 0, k_idx = 0;
  logic [31:0] hdr = '0;
  logic [23:0] rd_addr = '0;
  logic [7:0]  cur = '0;

  always @(negedge flash_cs_n) begin
    rcnt = 0;
    cs_falls++;
  end

  always @(posedge flash_cs_n)
    if (rst_n) chk(rcnt == 40 + 16*W, "R7 serial clocks per burst", rcnt, 40 + 16*W);

  always @(posedge flash_sck) if (!flash_cs_n) begin
    if (rcnt < 32) hdr = {hdr[30:0], io0_bus};
    rcnt++;
    if (rcnt == 32) begin
      chk(hdr[31:24] == 8'h3B, "R3 command byte", hdr[31:24], 8'h3B);
      chk(hdr[23:0] == SA, "R3 start address", hdr[23:0], SA);
      rd_addr = hdr[23:0];
    end
  end

  always @(negedge flash_sck) if (!flash_cs_n && rcnt >= 40) begin
    p_idx  = rcnt - 40;
    b_idx  = (p_idx / 4) % 4 + 4 * (p_idx / 16);
    k_idx  = p_idx % 4;
    cur    = fbyte(int'(rd_addr) + b_idx, seed);
    fl_io1 = cur[7 - 2*k_idx];
    fl_io0 = cur[6 - 2*k_idx];
  end

  // per-clock reference comparison
  int   wr_idx = 0, seg = 0, cs_hi = 0, cyc = 0;
  logic prev_sck = 1'b0, prev_cs = 1'b1, prev_io0 = 1'b0, prev_done = 1'b0;

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (flash_cs_n) chk(!flash_sck, "R2 clock idles low", flash_sck, 0);
      if (flash_sck && prev_sck && io0_oe)
        chk(io0_o == prev_io0, "R2 io0 stable while clock high", io0_o, prev_io0);
      if (flash_sck != prev_sck) begin
        chk(seg == H, "R11 half period length", seg, H);
        seg = 1;
      end else if (flash_cs_n != prev_cs) seg = 1;
      else seg++;
      if (!flash_cs_n && !flash_sck)
        chk(io0_oe == (rcnt < 32), "R4 io0 direction", io0_oe, rcnt < 32);
      if (ram_we) begin
        chk(wr_idx < W, "R7 write count", wr_idx, W - 1);
        chk(ram_addr == AW'(wr_idx), "R6 write address", ram_addr, wr_idx);
        chk(ram_wdata == exp_word(wr_idx), "R5 R6 packed word", ram_wdata, exp_word(wr_idx));
        wr_idx++;
      end
      cs_hi = flash_cs_n ? cs_hi + 1 : 0;
      if (done && !prev_done) chk(cs_hi >= 2*H, "R8 deselect before done", cs_hi, 2*H);
      if (busy) chk(!done, "R9 busy excludes done", done, 0);
    end
    prev_sck  = flash_sck;
    prev_cs   = flash_cs_n;
    prev_io0  = io0_o;
    prev_done = done;
  end

  task automatic pulse_start();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  task automatic wait_done();
    while (!done) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic finish_run(input string tag);
    chk(wr_idx == W, {tag, " R7 words written"}, wr_idx, W);
    chk(cs_falls == 1, {tag, " R9 single burst"}, cs_falls, 1);
    chk(!busy && done, {tag, " R8 done flag"}, {busy, done}, 2'b01);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(flash_cs_n && !flash_sck && !busy && !done && !ram_we && !io0_oe,
        "R1 reset state", {flash_cs_n, flash_sck, busy, done, ram_we, io0_oe}, 6'b100000);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(flash_cs_n && !busy && !done && !ram_we, "R1 idle after reset",
        {flash_cs_n, busy, done, ram_we}, 4'b1000);

    // run 1: start ignored during header and data
    seed = 1; wr_idx = 0; cs_falls = 0;
    pulse_start();
    chk(busy && !flash_cs_n, "R9 busy after start", {busy, flash_cs_n}, 2'b10);
    while (rcnt < 4) @(negedge clk);
    pulse_start();
    while (rcnt < 70) @(negedge clk);
    pulse_start();
    wait_done();
    finish_run("run1");
    repeat (20) @(negedge clk);
    chk(done && flash_cs_n && !flash_sck, "R8 done holds", {done, flash_cs_n, flash_sck}, 3'b110);

    // run 2: restart from done with a new pattern
    seed = 2; wr_idx = 0; cs_falls = 0;
    pulse_start();
    chk(!done && busy, "R10 restart clears done", {done, busy}, 2'b01);
    wait_done();
    finish_run("run2 R10");

    // run 3: start during the closing gap
    seed = 7; wr_idx = 0; cs_falls = 0;
    pulse_start();
    while (!flash_cs_n) @(negedge clk);
    chk(busy, "R9 busy during gap", busy, 1);
    pulse_start();
    wait_done();
    finish_run("run3");
    repeat (10) @(negedge clk);
    chk(cs_falls == 1 && flash_cs_n, "R9 gap start ignored", cs_falls, 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=%0d expected=done", cyc);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule